// File: doc/BRIEF.md
# Subframe Sync Detector with Position Match

This block sits behind the bit-recovery and word-assembly stages of a receiver for a continuous frame-structured data stream. It receives one 12-bit word for each `wordValid` strobe and finds where each subframe starts. A frame has four subframes. Each subframe opens with its own 12-bit sync pattern and holds `SF_LEN` words, including that pattern. While the block is searching, it remembers the sync patterns of the last `SF_LEN` words. It declares lock only when the pattern of subframe k+1 arrives exactly `SF_LEN` words after the pattern of subframe k. Sync-like values inside user data therefore cannot cause a false lock, and they cannot hold off a real one. After two genuine marks, lock follows at once.

Once locked, the block counts words within the subframe and tracks the subframe index. It checks every expected sync mark, and a single missing mark drops lock. In that case it flags that the subframe just received must be discarded. A store strobe and a registered copy of the word feed the receive buffer. A capture-all mode bypasses synchronisation entirely. A match output marks the one word whose count and subframe equal the values programmed by the user.

Every output is registered. It changes on the clock edge that samples a valid word and describes that word, so it is visible in the following cycle.

Top module: `subframe_sync`

## Requirements
- R1: While reset is held, and after reset until the first valid word, `inSync`, `wordCount`, `subframe`, `storeEn`, `lossPulse` and `matchPulse` are all 0.
- R2: The sync patterns are 0x247, 0x5B8, 0xA47 and 0xDB8 for subframes 0 to 3. While searching, a word that carries pattern k+1 (mod 4) exactly `SF_LEN` words after a word carrying pattern k sets `inSync`, sets `wordCount` to 1 and `subframe` to k+1, and stores that word.
- R3: While searching, the following do not lock: pattern pairs at any other spacing, pairs in the wrong subframe order, and isolated patterns. Earlier spurious patterns do not stop a correct pair from locking.
- R4: While locked, `wordCount` rises by one for each valid word from 1 up to `SF_LEN`. Word contents, including sync patterns inside the subframe, have no effect.
- R5: While locked, the word after count `SF_LEN` must carry the pattern of `subframe`+1, where subframe 3 wraps to 0. When it does, `wordCount` becomes 1 and `subframe` advances.
- R6: If that word is not the expected pattern, `inSync` clears, `wordCount` and `subframe` return to 0, the word is not stored, and `lossPulse` is high for one cycle to mark the previous subframe invalid. The full search then restarts.
- R7: `storeEn` is high for one cycle after each valid word accepted in sync or in capture-all mode, with the word on `dataOut`. It never fires during search.
- R8: With `noSyncMode` set, every valid word is stored, `inSync`, `wordCount` and `subframe` stay 0, and no sync pattern causes lock.
- R9: `matchPulse` rises with a word when `inSync` is set, `wordCount` equals `matchWord` and `subframe` equals `matchSubframe`. It stays high until the next valid word and is never high out of sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | One received word is present on `wordIn` |
| wordIn | input | 12 | Received word |
| noSyncMode | input | 1 | Capture-all mode, overrides synchronisation |
| matchWord | input | CNT_W ($clog2(SF_LEN+1), 7 by default) | Programmed word position for the match |
| matchSubframe | input | 2 | Programmed subframe for the match |
| inSync | output | 1 | Subframe lock held |
| wordCount | output | CNT_W | Position of the last word in its subframe, 1-based; 0 when not locked |
| subframe | output | 2 | Subframe index of the last word |
| storeEn | output | 1 | Write strobe for the receive buffer |
| dataOut | output | 12 | Registered copy of the last valid word |
| lossPulse | output | 1 | One-cycle flag: expected mark missed, discard previous subframe |
| matchPulse | output | 1 | Programmed position reached |

## Verification
The assertions check on every cycle the following properties. A lock always begins at count 1, and the count stays within 1 to `SF_LEN` while locked. A subframe boundary always advances the index by one. A loss pulse never comes with a store, and stores happen only for words that were accepted. Capture-all words are always stored without lock, and a match only occurs while locked. The bench scenarios cover what the properties cannot express: the pattern spacing and order needed to lock, rejection of planted false marks before and after lock, the 3-to-0 wrap, the match being held across idle cycles, and the search restarting after a mark is missed.

// File: rtl/sfsync_pkg.sv
package sfsync_pkg;
  localparam int WORD_W = 12;
  localparam int NUM_SF = 4;

  typedef struct packed {
    logic shiftEn;
    logic histClr;
  } ctlStrobes_t;

  function automatic logic [WORD_W-1:0] syncPattern(input logic [1:0] idx);
    case (idx)
      2'd0:    return 12'h247;
      2'd1:    return 12'h5B8;
      2'd2:    return 12'hA47;
      default: return 12'hDB8;
    endcase
  endfunction
endpackage

// File: rtl/sfsync_datapath.sv
module sfsync_datapath
  import sfsync_pkg::*;
#(
  parameter int SF_LEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordIn,
  input  ctlStrobes_t       ctl,
  output logic              syncHit,
  output logic [1:0]        syncIdx,
  output logic              chainHit,
  output logic [WORD_W-1:0] dataOut
);
  // Classify the incoming word against the four patterns
  always_comb begin
    syncHit = 1'b0;
    syncIdx = 2'd0;
    for (int k = 0; k < NUM_SF; k++) begin
      if (wordIn == syncPattern(2'(k))) begin
        syncHit = 1'b1;
        syncIdx = 2'(k);
      end
    end
  end

  // History of pattern hits over the last SF_LEN words; stage SF_LEN-1 is the
  // word exactly one subframe before the current one
  logic [SF_LEN-1:0] histHit;
  logic [1:0]        histIdx [SF_LEN];

  for (genvar g = 0; g < SF_LEN; g++) begin : g_hist
    logic       inHit;
    logic [1:0] inIdx;
    if (g == 0) begin : g_head
      assign inHit = syncHit;
      assign inIdx = syncIdx;
    end else begin : g_body
      assign inHit = histHit[g-1];
      assign inIdx = histIdx[g-1];
    end
    always_ff @(posedge clk) begin
      if (!rstN || ctl.histClr) begin
        histHit[g] <= 1'b0;
        histIdx[g] <= 2'd0;
      end else if (ctl.shiftEn) begin
        histHit[g] <= inHit;
        histIdx[g] <= inIdx;
      end
    end
  end

  assign chainHit = syncHit && histHit[SF_LEN-1] &&
                    (histIdx[SF_LEN-1] == syncIdx - 2'd1);

  always_ff @(posedge clk) begin
    if (!rstN)          dataOut <= '0;
    else if (wordValid) dataOut <= wordIn;
  end
endmodule

// File: rtl/sfsync_control.sv
module sfsync_control
  import sfsync_pkg::*;
#(
  parameter int SF_LEN = 64,
  localparam int CNT_W = $clog2(SF_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wordValid,
  input  logic             noSyncMode,
  input  logic [CNT_W-1:0] matchWord,
  input  logic [1:0]       matchSubframe,
  input  logic             syncHit,
  input  logic [1:0]       syncIdx,
  input  logic             chainHit,
  output ctlStrobes_t      ctl,
  output logic             inSync,
  output logic [CNT_W-1:0] wordCount,
  output logic [1:0]       subframe,
  output logic             storeEn,
  output logic             lossPulse,
  output logic             matchPulse
);
  logic             nIn, nStore, nLoss, nMatch;
  logic [CNT_W-1:0] nCnt;
  logic [1:0]       nSf;

  always_comb begin
    nIn    = inSync;
    nCnt   = wordCount;
    nSf    = subframe;
    nStore = 1'b0;
    nLoss  = 1'b0;
    nMatch = matchPulse;
    if (wordValid) begin
      if (noSyncMode) begin
        nIn = 1'b0; nCnt = '0; nSf = 2'd0; nStore = 1'b1;
      end else if (inSync) begin
        if (wordCount == CNT_W'(SF_LEN)) begin
          if (syncHit && (syncIdx == subframe + 2'd1)) begin
            nCnt = CNT_W'(1); nSf = syncIdx; nStore = 1'b1;
          end else begin
            nIn = 1'b0; nCnt = '0; nSf = 2'd0; nLoss = 1'b1;
          end
        end else begin
          nCnt = wordCount + CNT_W'(1); nStore = 1'b1;
        end
      end else if (chainHit) begin
        nIn = 1'b1; nCnt = CNT_W'(1); nSf = syncIdx; nStore = 1'b1;
      end
      nMatch = nIn && (nCnt == matchWord) && (nSf == matchSubframe);
    end
  end

  assign ctl.shiftEn = wordValid && !inSync && !noSyncMode;
  assign ctl.histClr = inSync || noSyncMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSync     <= 1'b0;
      wordCount  <= '0;
      subframe   <= 2'd0;
      storeEn    <= 1'b0;
      lossPulse  <= 1'b0;
      matchPulse <= 1'b0;
    end else begin
      inSync     <= nIn;
      wordCount  <= nCnt;
      subframe   <= nSf;
      storeEn    <= nStore;
      lossPulse  <= nLoss;
      matchPulse <= nMatch;
    end
  end

  a_r2_lock_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inSync) |-> wordCount == CNT_W'(1) && storeEn);
  a_r4_count_range: assert property (@(posedge clk) disable iff (!rstN)
    inSync |-> wordCount != '0 && wordCount <= CNT_W'(SF_LEN));
  a_r5_advance: assert property (@(posedge clk) disable iff (!rstN)
    $past(inSync) && inSync && $past(wordValid) && $past(wordCount) == CNT_W'(SF_LEN)
      |-> wordCount == CNT_W'(1) && subframe == $past(subframe) + 2'd1);
  a_r6_loss: assert property (@(posedge clk) disable iff (!rstN)
    lossPulse |-> !inSync && !storeEn && $past(inSync));
  a_r7_store: assert property (@(posedge clk) disable iff (!rstN)
    storeEn |-> $past(wordValid) && (inSync || $past(noSyncMode)));
  a_r8_nosync: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(wordValid) && $past(noSyncMode) |-> storeEn && !inSync);
  a_r9_match: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> inSync);
endmodule

// File: rtl/subframe_sync.sv
module subframe_sync
  import sfsync_pkg::*;
#(
  parameter int SF_LEN = 64,
  localparam int CNT_W = $clog2(SF_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              noSyncMode,
  input  logic [CNT_W-1:0]  matchWord,
  input  logic [1:0]        matchSubframe,
  output logic              inSync,
  output logic [CNT_W-1:0]  wordCount,
  output logic [1:0]        subframe,
  output logic              storeEn,
  output logic [WORD_W-1:0] dataOut,
  output logic              lossPulse,
  output logic              matchPulse
);
  ctlStrobes_t ctl;
  logic        syncHit, chainHit;
  logic [1:0]  syncIdx;

  sfsync_datapath #(.SF_LEN(SF_LEN)) dp_i (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn), .ctl(ctl),
    .syncHit(syncHit), .syncIdx(syncIdx), .chainHit(chainHit), .dataOut(dataOut)
  );

  sfsync_control #(.SF_LEN(SF_LEN)) ctl_i (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .noSyncMode(noSyncMode),
    .matchWord(matchWord), .matchSubframe(matchSubframe),
    .syncHit(syncHit), .syncIdx(syncIdx), .chainHit(chainHit), .ctl(ctl),
    .inSync(inSync), .wordCount(wordCount), .subframe(subframe),
    .storeEn(storeEn), .lossPulse(lossPulse), .matchPulse(matchPulse)
  );
endmodule

// File: tb/subframe_sync_tb_top.sv
`timescale 1ns/1ps
module subframe_sync_tb_top;
  localparam int SF_LEN = 16;
  localparam int CNT_W  = $clog2(SF_LEN + 1);
  localparam logic [11:0] S0 = 12'h247, S1 = 12'h5B8, S2 = 12'hA47, S3 = 12'hDB8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wordValid = 1'b0;
  logic [11:0] wordIn = '0;
  logic noSyncMode = 1'b0;
  logic [CNT_W-1:0] matchWord = CNT_W'(5);
  logic [1:0] matchSubframe = 2'd2;
  logic inSync, storeEn, lossPulse, matchPulse;
  logic [CNT_W-1:0] wordCount;
  logic [1:0] subframe;
  logic [11:0] dataOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  subframe_sync #(.SF_LEN(SF_LEN)) dut_i (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordIn(wordIn),
    .noSyncMode(noSyncMode), .matchWord(matchWord), .matchSubframe(matchSubframe),
    .inSync(inSync), .wordCount(wordCount), .subframe(subframe), .storeEn(storeEn),
    .dataOut(dataOut), .lossPulse(lossPulse), .matchPulse(matchPulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [11:0] w);
    @(negedge clk);
    wordValid = 1'b1;
    wordIn = w;
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic sendData(input int n);
    for (int i = 0; i < n; i++) sendWord(12'h100 + 12'(i));
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1 inSync", int'(inSync), 0);
    chk("R1 storeEn", int'(storeEn), 0);
    chk("R1 wordCount/subframe", int'(wordCount) + int'(subframe), 0);
    chk("R1 loss/match", int'(lossPulse) + int'(matchPulse), 0);
  endtask

  task automatic testNoSync();
    noSyncMode = 1'b1;
    sendWord(12'h0AB);
    chk("R8 stored", int'(storeEn), 1);
    chk("R7 dataOut", int'(dataOut), 12'h0AB);
    sendWord(S0);
    sendData(SF_LEN - 1);
    sendWord(S1);
    chk("R8 no lock", int'(inSync), 0);
    chk("R8 count", int'(wordCount), 0);
    chk("R8 store on pattern", int'(storeEn), 1);
    noSyncMode = 1'b0;
  endtask

  task automatic testWrongOrder();
    sendWord(S0);
    chk("R7 no store in search", int'(storeEn), 0);
    sendData(SF_LEN - 1);
    sendWord(S2);
    chk("R3 wrong order no lock", int'(inSync), 0);
  endtask

  task automatic testFalseMarksLock();
    sendWord(S0);        // spurious, pos 0
    sendData(2);
    sendWord(S0);        // genuine, pos 3
    sendData(3);
    sendWord(S1);        // spacing 4, pos 7
    chk("R3 short spacing no lock", int'(inSync), 0);
    sendData(11);        // pos 8..18 (pos 16 = data)
    chk("R3 still searching", int'(inSync), 0);
    sendWord(S1);        // pos 19
    chk("R2 lock", int'(inSync), 1);
    chk("R2 count", int'(wordCount), 1);
    chk("R2 subframe", int'(subframe), 1);
    chk("R2 stored", int'(storeEn), 1);
  endtask

  task automatic testTrackAndMatch();
    sendData(3);
    chk("R4 count", int'(wordCount), 4);
    sendData(3);
    sendWord(S3);        // false mark at count 8
    chk("R4 pattern ignored count", int'(wordCount), 8);
    chk("R4 pattern ignored sync", int'(inSync), 1);
    sendData(SF_LEN - 8);
    chk("R4 full count", int'(wordCount), SF_LEN);
    sendWord(S2);
    chk("R5 subframe 2", int'(subframe), 2);
    chk("R5 count reset", int'(wordCount), 1);
    sendData(3);
    chk("R9 no match early", int'(matchPulse), 0);
    sendData(1);
    chk("R9 match", int'(matchPulse), 1);
    repeat (4) @(negedge clk);
    chk("R9 match held", int'(matchPulse), 1);
    sendData(1);
    chk("R9 match ends", int'(matchPulse), 0);
    sendData(SF_LEN - 6);
    sendWord(S3);
    chk("R5 subframe 3", int'(subframe), 3);
    sendData(SF_LEN - 1);
    sendWord(S0);
    chk("R5 wrap to 0", int'(subframe), 0);
    chk("R5 wrap count", int'(wordCount), 1);
  endtask

  task automatic testLoss();
    sendData(SF_LEN - 1);
    chk("R7 store locked", int'(storeEn), 1);
    sendWord(S2);        // expected S1
    chk("R6 sync lost", int'(inSync), 0);
    chk("R6 loss pulse", int'(lossPulse), 1);
    chk("R6 not stored", int'(storeEn), 0);
    chk("R6 count cleared", int'(wordCount), 0);
    @(negedge clk);
    chk("R6 loss one cycle", int'(lossPulse), 0);
    sendWord(S0);
    sendData(SF_LEN - 1);
    sendWord(S1);
    chk("R6 search restarts", int'(inSync), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 inSync in reset", int'(inSync), 0);
    rstN = 1'b1;
    testReset();
    testNoSync();
    testWrongOrder();
    testFalseMarksLock();
    testTrackAndMatch();
    testLoss();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule